// File: doc/BRIEF.md
# Dual-Copy Time-Multiplexed Register File

This block is a small general-purpose register file with a built-in arithmetic unit. It does not use a memory with two read ports and one write port. It keeps two single-port synchronous arrays that always hold identical contents. A sequencer runs each operation in fixed phases:

- Read: array A is addressed by the first source index and array B by the second.
- Execute: array B keeps its address, and the array A word is captured into an operand buffer.
- Write-back: the buffer and the array B read data feed the unit, and the result is written to the destination index in both arrays in the same cycle.
- Done: a one-cycle completion pulse, with the result held on an output.

A controller issues an operation with a one-cycle start strobe together with an opcode, a destination index and two source indices. It then waits for the completion pulse. While the sequencer is idle, a debug port reads any register through array A, and a preload port writes a value into both copies. Only the preload port and the operations themselves change register contents.

Top module: `dupram_regfile`

## Requirements
- R1: Reset forces the sequencer idle and drives `done` and `result` to 0. Reset leaves the register contents unchanged.
- R2: Opcode 2'b00 (move) writes R[src_a] to R[dst] and presents it on `result`; `src_b_idx` is not used.
- R3: Opcode 2'b01 (increment) writes R[src_a]+1 modulo 256 to R[dst], so 8'hFF becomes 8'h00; `src_b_idx` is not used.
- R4: Opcode 2'b10 (add) writes (R[src_a]+R[src_b]) modulo 256 to R[dst].
- R5: Opcode 2'b11 (subtract) writes (R[src_a]-R[src_b]) modulo 256 to R[dst], wrapping on borrow.
- R6: `done` goes high for exactly one cycle, four rising edges after the edge that accepts `start`. `result` changes only in the cycle where `done` is high and holds its value until the next `done`.
- R7: `start` is ignored unless the sequencer is idle. A strobe during an operation starts nothing, writes nothing and does not alter the running operation.
- R8: When `dst_idx` equals a source index, the operation uses the value the register held before the operation. The next operation sees the new value.
- R9: An operation changes only R[dst]. After every write, both copies hold the same word at the written index: array A is observed through the debug port and array B through the second operand of an add.
- R10: `dbg_data` shows R[`dbg_addr`] one rising edge after `dbg_addr` is presented while the sequencer is idle.
- R11: `pl_we` high at a rising edge where the sequencer is idle and `start` is low writes `pl_data` to R[`pl_addr`] in both copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| start | input | 1 | Operation request strobe |
| opcode | input | 2 | 00 move, 01 increment, 10 add, 11 subtract |
| dst_idx | input | 3 | Destination register index |
| src_a_idx | input | 3 | First source index (array A) |
| src_b_idx | input | 3 | Second source index (array B) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Last written result |
| dbg_addr | input | 3 | Debug read index |
| dbg_data | output | 8 | Debug read data from array A |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 3 | Preload index |
| pl_data | input | 8 | Preload value |

## Verification
The completion pulse and a new `result` are due four rising edges after the edge that accepts `start`. The bench counts falling edges from that point and checks that the count is four and that the pulse falls at the next edge. Debug data is due one edge after the address is presented in idle, and preload data is visible to a debug read issued after the write edge. The bench drives and samples on falling edges only, so each check falls midway between the edge that produces a value and the edge that consumes it.

// File: rtl/dupram_pkg.sv
package dupram_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_EXEC  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_MOV = 2'b00,
    OP_INC = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } op_e;

  localparam int unsigned NCOPY = 2;

endpackage

// File: rtl/dupram_bank.sv
module dupram_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // single port: a write cycle does not refresh the read register
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    rdata_q   <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dupram_alu.sv
module dupram_alu #(
  parameter int DW = 8
) (
  input  dupram_pkg::op_e op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y
);
  import dupram_pkg::*;

  function automatic logic [DW-1:0] calc(op_e o, logic [DW-1:0] x, logic [DW-1:0] z);
    logic [DW-1:0] one;
    one = '0;
    one[0] = 1'b1;
    case (o)
      OP_MOV:  return x;
      OP_INC:  return x + one;
      OP_ADD:  return x + z;
      default: return x - z;
    endcase
  endfunction

  assign y = calc(op, a, b);
endmodule

// File: rtl/dupram_seq.sv
module dupram_seq #(
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op_i,
  input  logic [AW-1:0]       dst_i,
  input  logic [AW-1:0]       sa_i,
  input  logic [AW-1:0]       sb_i,
  input  logic                pl_we,
  input  logic [AW-1:0]       pl_addr,
  input  logic [AW-1:0]       dbg_addr,
  output dupram_pkg::seq_st_e st,
  output dupram_pkg::op_e     op_q,
  output logic [AW-1:0]       addr_a,
  output logic [AW-1:0]       addr_b,
  output logic                mem_we,
  output logic                wsel_alu,
  output logic                buf_ld,
  output logic                res_ld,
  output logic                start_ok,
  output logic                done
);
  import dupram_pkg::*;

  seq_st_e       st_q, st_d;
  logic [AW-1:0] dst_q, sa_q, sb_q;

  assign start_ok = start && (st_q == S_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start_ok) st_d = S_READ;
      S_READ:  st_d = S_EXEC;
      S_EXEC:  st_d = S_WRITE;
      S_WRITE: st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (start_ok) begin
      op_q  <= op_e'(op_i);
      dst_q <= dst_i;
      sa_q  <= sa_i;
      sb_q  <= sb_i;
    end
  end

  // address multiplexing per phase
  always_comb begin
    addr_a = dbg_addr;
    addr_b = dbg_addr;
    mem_we = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (pl_we && !start) begin
          addr_a = pl_addr;
          addr_b = pl_addr;
          mem_we = 1'b1;
        end
      end
      S_READ, S_EXEC: begin
        addr_a = sa_q;
        addr_b = sb_q;          // held through execute
      end
      S_WRITE: begin
        addr_a = dst_q;
        addr_b = dst_q;
        mem_we = 1'b1;
      end
      default: begin            // done: read back for copy compare
        addr_a = dst_q;
        addr_b = dst_q;
      end
    endcase
  end

  assign st       = st_q;
  assign wsel_alu = (st_q == S_WRITE);
  assign buf_ld   = (st_q == S_EXEC);
  assign res_ld   = (st_q == S_WRITE);
  assign done     = (st_q == S_DONE);
endmodule

// File: rtl/dupram_regfile.sv
module dupram_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    opcode,
  input  logic [AW-1:0] dst_idx,
  input  logic [AW-1:0] src_a_idx,
  input  logic [AW-1:0] src_b_idx,
  output logic          done,
  output logic [DW-1:0] result,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data
);
  import dupram_pkg::*;

  // named internal events, used by the checker
  seq_st_e       seq_state;
  op_e           op_q;
  logic          start_ok, mem_we, wsel_alu, buf_ld, res_ld;
  logic [AW-1:0] addr_a, addr_b;
  logic [AW-1:0] bank_addr [NCOPY];
  logic [DW-1:0] bank_rd   [NCOPY];
  logic [DW-1:0] rd_a, rd_b, wdata, alu_y, buf_q, result_q;

  dupram_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(opcode),
    .dst_i(dst_idx), .sa_i(src_a_idx), .sb_i(src_b_idx),
    .pl_we(pl_we), .pl_addr(pl_addr), .dbg_addr(dbg_addr),
    .st(seq_state), .op_q(op_q), .addr_a(addr_a), .addr_b(addr_b),
    .mem_we(mem_we), .wsel_alu(wsel_alu), .buf_ld(buf_ld),
    .res_ld(res_ld), .start_ok(start_ok), .done(done)
  );

  assign bank_addr[0] = addr_a;
  assign bank_addr[1] = addr_b;
  assign wdata        = wsel_alu ? alu_y : pl_data;

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    dupram_bank #(.DW(DW), .DEPTH(NREG)) u_bank (
      .clk(clk), .we(mem_we), .addr(bank_addr[c]),
      .wdata(wdata), .rdata(bank_rd[c])
    );
  end

  assign rd_a = bank_rd[0];
  assign rd_b = bank_rd[1];

  // operand buffer: array A word captured, array B word used live
  always_ff @(posedge clk) begin
    if (buf_ld) buf_q <= rd_a;
  end

  dupram_alu #(.DW(DW)) u_alu (.op(op_q), .a(buf_q), .b(rd_b), .y(alu_y));

  always_ff @(posedge clk) begin
    if (!rst_n)      result_q <= '0;
    else if (res_ld) result_q <= alu_y;
  end

  assign result   = result_q;
  assign dbg_data = rd_a;
endmodule

// File: rtl/dupram_regfile_chk.sv
module dupram_regfile_chk #(
  parameter int DW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input dupram_pkg::seq_st_e st,
  input logic                start_ok,
  input logic                done,
  input logic [DW-1:0]       result,
  input logic [DW-1:0]       rd_a,
  input logic [DW-1:0]       rd_b
);
  import dupram_pkg::*;

  a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> ##4 done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r7_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> (st != S_READ));

  a_r9_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |=> (rd_a == rd_b));
endmodule

bind dupram_regfile dupram_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(seq_state), .start_ok(start_ok),
  .done(done), .result(result), .rd_a(rd_a), .rd_b(rd_b)
);

// File: tb/sim_dupram_regfile.sv
`timescale 1ns/1ps
module sim_dupram_regfile;
  logic       clk = 1'b0;
  logic       rst_n, start, pl_we, done;
  logic [1:0] opcode;
  logic [2:0] dst_idx, src_a_idx, src_b_idx, dbg_addr, pl_addr;
  logic [7:0] result, dbg_data, pl_data;

  logic [7:0] mdl [8];
  int nchk  = 0;
  int nfail = 0;
  logic [7:0] r;

  always #2.5 clk = ~clk;

  dupram_regfile u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .dst_idx(dst_idx), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .done(done), .result(result), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_op(input logic [1:0] op, input logic [7:0] x, input logic [7:0] z);
    if (op == 2'b00) return x;
    if (op == 2'b01) return 8'((int'(x) + 1) % 256);
    if (op == 2'b10) return 8'((int'(x) + int'(z)) % 256);
    return 8'((int'(x) - int'(z) + 256) % 256);
  endfunction

  task automatic preload(input int a, input logic [7:0] v);
    @(negedge clk); pl_we = 1'b1; pl_addr = a[2:0]; pl_data = v;
    @(negedge clk); pl_we = 1'b0;
    mdl[a] = v;
  endtask

  task automatic dbg_read(input int a, output logic [7:0] v);
    @(negedge clk); dbg_addr = a[2:0];
    @(negedge clk); v = dbg_data;
  endtask

  task automatic do_op(input logic [1:0] op, input int d, input int a, input int b,
                       input string req, output logic [7:0] res);
    logic [7:0] exp;
    int k;
    exp = ref_op(op, mdl[a], mdl[b]);
    @(negedge clk);
    start = 1'b1; opcode = op; dst_idx = d[2:0]; src_a_idx = a[2:0]; src_b_idx = b[2:0];
    @(negedge clk); start = 1'b0;
    k = 1;
    while (!done && k < 20) begin @(negedge clk); k++; end
    chk({req, " R6 latency"}, 8'(k), 8'd4);
    res = result;
    chk(req, res, exp);
    @(negedge clk);
    chk({req, " R6 done width"}, {7'd0, done}, 8'd0);
    mdl[d] = exp;
  endtask

  task automatic t_reset_preload();
    logic [7:0] v;
    chk("R1 done after reset", {7'd0, done}, 8'd0);
    chk("R1 result after reset", result, 8'd0);
    for (int i = 0; i < 8; i++) preload(i, 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 8; i++) begin
      dbg_read(i, v);
      chk("R10 R11 preload/debug", v, mdl[i]);
    end
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 done after second reset", {7'd0, done}, 8'd0);
    for (int i = 0; i < 8; i++) begin
      dbg_read(i, v);
      chk("R1 contents kept", v, mdl[i]);
    end
  endtask

  task automatic t_move();
    logic [7:0] v;
    do_op(2'b00, 1, 4, 7, "R2 move", r);
    dbg_read(1, v); chk("R2 move dest", v, mdl[1]);
    do_op(2'b00, 6, 0, 3, "R2 move", r);
  endtask

  task automatic t_inc();
    logic [7:0] v;
    do_op(2'b01, 2, 5, 0, "R3 inc", r);
    preload(3, 8'hFF);
    do_op(2'b01, 3, 3, 1, "R3 inc wrap", r);
    dbg_read(3, v); chk("R3 inc wrap dest", v, 8'h00);
  endtask

  task automatic t_add();
    preload(4, 8'h7F); preload(5, 8'h01);
    do_op(2'b10, 0, 4, 5, "R4 add", r);
    preload(4, 8'hC8); preload(5, 8'h64);
    do_op(2'b10, 7, 4, 5, "R4 add overflow", r);
    do_op(2'b10, 1, 7, 0, "R4 add", r);
  endtask

  task automatic t_sub();
    preload(4, 8'h50); preload(5, 8'h20);
    do_op(2'b11, 2, 4, 5, "R5 sub", r);
    do_op(2'b11, 6, 5, 4, "R5 sub borrow", r);
    do_op(2'b11, 3, 4, 4, "R5 sub self", r);
  endtask

  task automatic t_same_reg();
    preload(2, 8'h21);
    do_op(2'b10, 2, 2, 2, "R8 dst=src add", r);
    chk("R8 old value used", r, 8'h42);
    do_op(2'b00, 5, 2, 0, "R8 new value seen", r);
    chk("R8 new value seen", r, 8'h42);
    do_op(2'b01, 5, 5, 5, "R8 dst=src inc", r);
    chk("R8 inc old value", r, 8'h43);
  endtask

  task automatic t_ignore_start();
    logic [7:0] v, exp;
    int k;
    preload(6, 8'h10); preload(1, 8'h05); preload(7, 8'hAA);
    exp = 8'h15;
    @(negedge clk);
    start = 1'b1; opcode = 2'b10; dst_idx = 3'd0; src_a_idx = 3'd6; src_b_idx = 3'd1;
    @(negedge clk);
    start = 1'b1; opcode = 2'b11; dst_idx = 3'd7; src_a_idx = 3'd1; src_b_idx = 3'd6;
    @(negedge clk); start = 1'b0;
    k = 2;
    while (!done && k < 20) begin @(negedge clk); k++; end
    chk("R7 latency unchanged", 8'(k), 8'd4);
    chk("R7 running op result", result, exp);
    mdl[0] = exp;
    k = 0;
    repeat (8) begin @(negedge clk); if (done) k++; end
    chk("R7 no second done", 8'(k), 8'd0);
    chk("R7 result held", result, exp);
    dbg_read(7, v); chk("R7 stray dest untouched", v, 8'hAA);
  endtask

  task automatic t_copies();
    logic [7:0] v;
    preload(0, 8'h00);
    do_op(2'b10, 4, 6, 1, "R9 write", r);
    for (int i = 0; i < 8; i++) begin
      dbg_read(i, v); chk("R9 copy A contents", v, mdl[i]);
    end
    preload(0, 8'h00);
    for (int i = 1; i < 8; i++) begin
      logic [7:0] want;
      want = mdl[i];
      do_op(2'b10, 0, 0, i, "R9 copy B read", r);
      chk("R9 copy B matches", r, want);
      preload(0, 8'h00);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pl_we = 1'b0; opcode = 2'b00;
    dst_idx = '0; src_a_idx = '0; src_b_idx = '0; dbg_addr = '0;
    pl_addr = '0; pl_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_preload();
    t_move();
    t_inc();
    t_add();
    t_sub();
    t_same_reg();
    t_ignore_start();
    t_copies();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule